// File: doc/BRIEF.md
# Strobe Window Delay Tracking Loop

This block keeps a data strobe centred inside a narrow sampling window. On each update it receives a pair of window samples. The early sample is taken by a clock slightly ahead of the window centre, and the late sample by a clock slightly behind it. When the early sample reads 0 and the late sample reads 1, the strobe edge sits between the two clocks and the window is correctly placed. A pair of 1/1 means the strobe edge is early, so the delay must grow. A pair of 0/0 means the edge is late, so the delay must shrink.

The loop does not move the delay on every disagreement. Votes are summed in a signed accumulator. The delay code moves one step only when the sum reaches a threshold, and that threshold rises as the window skew setting narrows. One shared 9-bit code drives both the strobe delay line and the data-sample delay line. The block also reports a lock flag and a small status word that a controller polls during bring-up.

Top module: `strobe_window_tracker`

## Requirements
- R1: While reset is held, and right after it is released, both delay codes read 167, the lock flag reads 0 and the status word reads 0x00.
- R2: When an update arrives with enable and track both set, a pair of early=1 and late=1 is an up vote and adds 1 to the accumulator. When the accumulator reaches the threshold, both codes rise by 1 and the accumulator clears. Up and down votes cancel each other.
- R3: Under the same conditions, a pair of early=0 and late=0 is a down vote and subtracts 1 from the accumulator. When the accumulator reaches minus the threshold, both codes fall by 1 and the accumulator clears.
- R4: The threshold is 4 × (16 − skew), where skew is the 4-bit window skew input. A skew of 15 gives a threshold of 4 and a skew of 0 gives 64, so a narrower setting responds more slowly.
- R5: The codes saturate instead of wrapping. Further up steps at 511 hold the code at 511, and further down steps at 0 hold it at 0.
- R6: The lock flag sets on the 64th consecutive tracking update whose pair reads early=0 and late=1. After only 63 such updates it is still clear.
- R7: A tracking update whose pair reads 1/1 or 0/0 clears the lock flag in that same update.
- R8: While the enable bit (ctrl bit 0) is 0, the codes hold, the accumulator and the lock run clear, the lock flag clears and the status word reads 0x00.
- R9: With enable set and the track bit (ctrl bit 1) clear, updates are ignored: the codes, accumulator and lock flag hold, and the status word reads 0x00.
- R10: While enable and track are both set, the status word reads 0x05 when locked and 0x01 when unlocked.
- R11: A tracking update whose pair reads early=1 and late=0 casts no vote. It keeps the lock flag but restarts the run of consecutive centred updates.
- R12: Cycles in which the update strobe is low change neither the codes nor the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 2 | Bit 0 enables the loop, bit 1 selects track mode |
| skew | input | 4 | Window skew setting; a smaller value gives a slower loop |
| upd | input | 1 | Marks a cycle that carries a fresh sample pair |
| early_smp | input | 1 | Window sample taken by the early clock |
| late_smp | input | 1 | Window sample taken by the late clock |
| strobe_dly | output | 9 | Delay code for the strobe delay line |
| sample_dly | output | 9 | Delay code for the data-sample delay line |
| locked | output | 1 | Window is held centred |
| status | output | 8 | 0x05 locked and tracking, 0x01 tracking, 0x00 otherwise |

## Verification
The delay codes and the lock flag come from registers. A sample pair presented with upd high is therefore taken in at a rising edge, and its effect shows on both codes and the lock flag straight after that edge. The status word is combinational from the ctrl input and the lock register, so it follows a change of ctrl in the same cycle. The bench drives every input on a falling edge and samples the outputs on the falling edge after the last rising edge of a burst. Each check therefore sees exactly the updates counted into it: a threshold minus one, the threshold, 63 centred updates, or 64.

// File: rtl/strobe_window_tracker.sv
module strobe_window_tracker #(
  parameter int CODE_W     = 9,
  parameter int RESET_CODE = 167,
  parameter int SKEW_W     = 4,
  parameter int STEP_SCALE = 4,
  parameter int LOCK_RUN   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctrl,
  input  logic [SKEW_W-1:0] skew,
  input  logic              upd,
  input  logic              early_smp,
  input  logic              late_smp,
  output logic [CODE_W-1:0] strobe_dly,
  output logic [CODE_W-1:0] sample_dly,
  output logic              locked,
  output logic [7:0]        status
);
  localparam int SPAN     = 1 << SKEW_W;
  localparam int MAX_T    = STEP_SCALE * SPAN;
  localparam int ACC_W    = $clog2(MAX_T) + 2;
  localparam int RUN_W    = $clog2(LOCK_RUN + 1);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [CODE_W-1:0]       code;
  logic signed [ACC_W-1:0] acc, acc_nxt, thr;
  logic [RUN_W-1:0]        run;
  logic active, hit, vote_up, vote_dn, centred;

  assign active  = ctrl[0] & ctrl[1];
  assign hit     = upd & active;
  assign vote_up = early_smp & late_smp;
  assign vote_dn = ~early_smp & ~late_smp;
  assign centred = ~early_smp & late_smp;
  assign thr     = ACC_W'(STEP_SCALE) * (ACC_W'(SPAN) - ACC_W'(skew));
  assign acc_nxt = vote_up ? acc + ACC_W'(1) : acc - ACC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code   <= CODE_W'(RESET_CODE);
      acc    <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else if (!ctrl[0]) begin
      acc    <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else if (hit) begin
      if (vote_up || vote_dn) begin
        run    <= '0;
        locked <= 1'b0;
        if (acc_nxt >= thr) begin
          acc <= '0;
          if (code != CODE_W'(CODE_MAX)) code <= code + CODE_W'(1);
        end else if (acc_nxt <= -thr) begin
          acc <= '0;
          if (code != '0) code <= code - CODE_W'(1);
        end else begin
          acc <= acc_nxt;
        end
      end else if (centred) begin
        if (run != RUN_W'(LOCK_RUN)) run <= run + RUN_W'(1);
        if (run == RUN_W'(LOCK_RUN - 1)) locked <= 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  assign strobe_dly = code;
  assign sample_dly = code;
  assign status     = active ? {5'b0, locked, 1'b0, 1'b1} : 8'h00;
endmodule

// File: rtl/strobe_window_tracker_chk.sv
module strobe_window_tracker_chk #(
  parameter int CODE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctrl,
  input logic              upd,
  input logic              early_smp,
  input logic              late_smp,
  input logic [CODE_W-1:0] strobe_dly,
  input logic              locked
);
  logic hit;
  assign hit = upd & ctrl[0] & ctrl[1];

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (strobe_dly == $past(strobe_dly)) ||
            (strobe_dly == $past(strobe_dly) + CODE_W'(1)) ||
            (strobe_dly == $past(strobe_dly) - CODE_W'(1)));

  p_no_wrap_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && strobe_dly == '1) |=> strobe_dly != '0);

  p_no_wrap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && strobe_dly == '0) |=> strobe_dly != '1);

  p_lock_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit && !early_smp && late_smp));

  p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && early_smp == late_smp) |=> !locked);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> !locked);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(strobe_dly));
endmodule

bind strobe_window_tracker strobe_window_tracker_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .upd(upd),
  .early_smp(early_smp), .late_smp(late_smp),
  .strobe_dly(strobe_dly), .locked(locked)
);

// File: tb/strobe_window_tracker_test.sv
module strobe_window_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ctrl = 2'b00;
  logic [3:0] skew = 4'd0;
  logic       upd = 1'b0, early_smp = 1'b0, late_smp = 1'b0;
  logic [8:0] strobe_dly, sample_dly;
  logic       locked;
  logic [7:0] status;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  strobe_window_tracker uut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .skew(skew), .upd(upd),
    .early_smp(early_smp), .late_smp(late_smp),
    .strobe_dly(strobe_dly), .sample_dly(sample_dly),
    .locked(locked), .status(status)
  );

  // {skew, early, late, update count, expected code, expected lock}
  localparam logic [27:0] VEC [11] = '{
    {4'd15, 1'b1, 1'b1, 12'd3,  9'd167, 1'b0},  // R2 one short of 4
    {4'd15, 1'b1, 1'b1, 12'd1,  9'd168, 1'b0},  // R2 step up
    {4'd15, 1'b0, 1'b0, 12'd8,  9'd166, 1'b0},  // R3 two steps down
    {4'd12, 1'b1, 1'b1, 12'd15, 9'd166, 1'b0},  // R4 threshold 16, one short
    {4'd12, 1'b1, 1'b1, 12'd1,  9'd167, 1'b0},  // R4 step at 16
    {4'd12, 1'b0, 1'b1, 12'd63, 9'd167, 1'b0},  // R6 63 centred
    {4'd12, 1'b0, 1'b1, 12'd1,  9'd167, 1'b1},  // R6 64th locks, R10
    {4'd12, 1'b1, 1'b0, 12'd5,  9'd167, 1'b1},  // R11 no vote, lock kept
    {4'd12, 1'b0, 1'b1, 12'd63, 9'd167, 1'b1},  // R11 run restarted, still locked
    {4'd12, 1'b1, 1'b1, 12'd1,  9'd167, 1'b0},  // R7 1/1 drops lock
    {4'd0,  1'b0, 1'b0, 12'd65, 9'd166, 1'b0}   // R4 threshold 64, cancels +1
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic burst(input logic e, input logic l, input int n);
    upd = 1'b1; early_smp = e; late_smp = l;
    repeat (n) @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 code in reset", int'(strobe_dly), 167);
    rst_n = 1'b1;
    idle(1);
    chk("R1 strobe code", int'(strobe_dly), 167);
    chk("R1 sample code", int'(sample_dly), 167);
    chk("R1 lock", int'(locked), 0);
    chk("R1 status", int'(status), 0);

    ctrl = 2'b11;
    for (int i = 0; i < 11; i++) begin
      skew = VEC[i][27:24];
      burst(VEC[i][23], VEC[i][22], int'(VEC[i][21:10]));
      chk($sformatf("R2/R3/R4/R6/R7/R11 row %0d code", i), int'(strobe_dly), int'(VEC[i][9:1]));
      chk($sformatf("R2 row %0d sample code", i), int'(sample_dly), int'(VEC[i][9:1]));
      chk($sformatf("R6/R7 row %0d lock", i), int'(locked), int'(VEC[i][0]));
      chk($sformatf("R10 row %0d status", i), int'(status), VEC[i][0] ? 5 : 1);
    end

    // R8 disabled: votes do nothing, status and lock are zero
    ctrl = 2'b00; skew = 4'd15;
    burst(1'b1, 1'b1, 20);
    chk("R8 code held", int'(strobe_dly), 166);
    chk("R8 status", int'(status), 0);
    chk("R8 lock", int'(locked), 0);

    // R8 accumulator cleared by disable
    ctrl = 2'b11;
    burst(1'b1, 1'b1, 3);
    ctrl = 2'b00; idle(1); ctrl = 2'b11;
    burst(1'b1, 1'b1, 3);
    chk("R8 accumulator cleared", int'(strobe_dly), 166);
    burst(1'b1, 1'b1, 1);
    chk("R8 fresh count steps", int'(strobe_dly), 167);

    // R9 enabled without track
    ctrl = 2'b01;
    burst(1'b1, 1'b1, 40);
    chk("R9 code held", int'(strobe_dly), 167);
    chk("R9 status", int'(status), 0);
    ctrl = 2'b11;

    // R12 no update strobe
    early_smp = 1'b1; late_smp = 1'b1;
    idle(20);
    chk("R12 code held", int'(strobe_dly), 167);

    // R5 saturation both ends
    burst(1'b1, 1'b1, 1600);
    chk("R5 saturate high", int'(strobe_dly), 511);
    burst(1'b0, 1'b0, 2080);
    chk("R5 saturate low", int'(strobe_dly), 0);
    burst(1'b0, 1'b0, 8);
    chk("R5 hold at zero", int'(sample_dly), 0);

    // R7 0/0 drops lock
    burst(1'b0, 1'b1, 64);
    chk("R6 lock again", int'(locked), 1);
    chk("R10 status locked", int'(status), 5);
    burst(1'b0, 1'b0, 1);
    chk("R7 0/0 drops lock", int'(locked), 0);
    chk("R10 status unlocked", int'(status), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule